// File: doc/BRIEF.md
# Gray-Stamped Event Word Serializer

This block turns channel events into fixed-width data words and sends them out two bits per clock. Two counters run in the data-clock domain. One is a 12-bit bunch-crossing counter that advances on a bunch-clock enable. The other is an 8-bit trigger counter that advances on each trigger-accept pulse. Both counters are kept in binary and converted to Gray code.

When an event is presented, its flag, threshold bit, channel address, amplitude and time are packed together with the Gray-coded counter values into a 48-bit word. The word is written into a 16-entry FIFO, which decouples bursts of events from the output. A serializer takes words from the FIFO and shifts each one out over 24 data-clock cycles on a 2-bit lane, most significant pair first. A one-cycle sync pulse marks the first pair of each word. Successive words follow each other with no gap.

An event that arrives while the FIFO is full is discarded. The first such loss sets a sticky overflow flag.

Top module: `evtWordStreamer`

## Requirements
- R1: After reset, serData is 00, serSync is 0, overflow is 0, and both counters hold zero.
- R2: The bunch counter increments by one on each cycle with bcTick high and wraps from 4095 to 0. It appears in word bits 19:8 as Gray code g = b ^ (b >> 1), so a count of 4095 reads 12'h800.
- R3: The trigger counter increments by one on each cycle with trigAccept high and wraps from 255 to 0. It appears in word bits 7:0 as Gray code, so a count of 255 reads 8'h80.
- R4: An event captures the counter values held before any increment that happens in the same cycle.
- R5: Word layout: bit 47 is the flag, bit 46 is the threshold bit, bits 45:40 are the address, bits 39:30 are the amplitude and bits 29:20 are the time.
- R6: A word occupies 24 consecutive beats. Beat j carries word bits 47-2j down to 46-2j on serData[1:0]. serSync is high on beat 0 only.
- R7: Beat 0 of a word reaches the outputs in the second cycle after the event is captured, provided the serializer is idle. When words are queued, the beat 0 of the next word directly follows beat 23 of the previous one.
- R8: While no word is being sent, serData is 00 and serSync is 0.
- R9: The FIFO holds 16 words in arrival order. An event presented while 16 words are stored is dropped and never appears on the output.
- R10: A dropped event sets overflow. overflow then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rstN | input | 1 | Active-low synchronous reset |
| bcTick | input | 1 | Bunch-clock enable, one cycle per bunch crossing |
| trigAccept | input | 1 | Trigger-accept pulse |
| evtValid | input | 1 | Event fields are valid this cycle |
| evtFlag | input | 1 | Event flag bit |
| evtThr | input | 1 | Threshold-crossed bit |
| evtAddr | input | 6 | Channel address |
| evtAmpl | input | 10 | Amplitude sample |
| evtTime | input | 10 | Time sample |
| serData | output | 2 | Serial data lane, two bits per clock |
| serSync | output | 1 | High on the first beat of each word |
| overflow | output | 1 | Sticky event-dropped flag |

## Verification
The bench builds the block with its default parameters: 12-bit and 8-bit counters, a 16-word FIFO and a 2-bit lane. With these sizes the bunch counter wraps after about four thousand ticks and the trigger counter after 256 pulses, so both Gray wrap values (12'h800 and 8'h80) and the return to zero can be reached directly. A burst of twenty back-to-back events against a 24-cycle drain per word fills the FIFO after seventeen writes. The same burst therefore exercises gapless streaming, drop-on-full and the sticky flag.

// File: rtl/evtw_pkg.sv
`timescale 1ns/1ps
package evtw_pkg;
  localparam int ADDR_W = 6;
  localparam int AMPL_W = 10;
  localparam int TIME_W = 10;

  // strobes from control to datapath
  typedef struct packed {
    logic push;   // write incoming word into the buffer
    logic pop;    // load head word into the shifter
    logic shift;  // advance the shifter by one lane
  } ctrl_t;
endpackage

// File: rtl/evtw_gray.sv
`timescale 1ns/1ps
module evtw_gray #(
  parameter int W = 8
) (
  input  logic [W-1:0] bin,
  output logic [W-1:0] gray
);
  assign gray[W-1] = bin[W-1];
  for (genvar i = 0; i < W - 1; i++) begin : gBit
    assign gray[i] = bin[i] ^ bin[i+1];
  end
endmodule

// File: rtl/evtw_control.sv
`timescale 1ns/1ps
module evtw_control
  import evtw_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int BEATS = 24,
  parameter int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtValid,
  output ctrl_t            strb,
  output logic             serSync,
  output logic             overflow,
  output logic [CNT_W-1:0] fillLevel
);
  localparam int BEAT_W = $clog2(BEATS);

  logic              busy;
  logic [BEAT_W-1:0] beat;
  logic              isFull;
  logic              isEmpty;
  logic              lastBeat;

  assign isFull   = (fillLevel == CNT_W'(FIFO_DEPTH));
  assign isEmpty  = (fillLevel == '0);
  assign lastBeat = busy && (beat == BEAT_W'(BEATS - 1));

  always_comb begin
    strb.push  = evtValid && !isFull;
    strb.pop   = (!busy || lastBeat) && !isEmpty;
    strb.shift = busy && !strb.pop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillLevel <= '0;
      busy      <= 1'b0;
      beat      <= '0;
      serSync   <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      fillLevel <= fillLevel + CNT_W'(strb.push) - CNT_W'(strb.pop);
      serSync   <= strb.pop;
      overflow  <= overflow | (evtValid && isFull);
      if (strb.pop) begin
        busy <= 1'b1;
        beat <= '0;
      end else if (lastBeat) begin
        busy <= 1'b0;
        beat <= '0;
      end else if (busy) begin
        beat <= beat + BEAT_W'(1);
      end
    end
  end
endmodule

// File: rtl/evtw_datapath.sv
`timescale 1ns/1ps
module evtw_datapath
  import evtw_pkg::*;
#(
  parameter int BC_W = 12,
  parameter int TRIG_W = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int LANE_W = 2,
  parameter int WORD_W = 2 + ADDR_W + AMPL_W + TIME_W + BC_W + TRIG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             strb,
  input  logic              bcTick,
  input  logic              trigAccept,
  input  logic              evtFlag,
  input  logic              evtThr,
  input  logic [ADDR_W-1:0] evtAddr,
  input  logic [AMPL_W-1:0] evtAmpl,
  input  logic [TIME_W-1:0] evtTime,
  output logic [LANE_W-1:0] serData,
  output logic [BC_W-1:0]   bcGray,
  output logic [TRIG_W-1:0] trigGray
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);

  logic [BC_W-1:0]   bcBin;
  logic [TRIG_W-1:0] trigBin;
  logic [WORD_W-1:0] newWord;
  logic [WORD_W-1:0] store [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [WORD_W-1:0] shifter;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bcBin   <= '0;
      trigBin <= '0;
    end else begin
      if (bcTick)     bcBin   <= bcBin + BC_W'(1);
      if (trigAccept) trigBin <= trigBin + TRIG_W'(1);
    end
  end

  evtw_gray #(.W(BC_W))   uBcGray   (.bin(bcBin),   .gray(bcGray));
  evtw_gray #(.W(TRIG_W)) uTrigGray (.bin(trigBin), .gray(trigGray));

  assign newWord = {evtFlag, evtThr, evtAddr, evtAmpl, evtTime, bcGray, trigGray};

  always_ff @(posedge clk) begin
    if (strb.push) store[wrPtr] <= newWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      shifter <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + PTR_W'(1);
      if (strb.pop) begin
        shifter <= store[rdPtr];
        rdPtr   <= rdPtr + PTR_W'(1);
      end else if (strb.shift) begin
        shifter <= shifter << LANE_W;
      end
    end
  end

  assign serData = shifter[WORD_W-1 -: LANE_W];
endmodule

// File: rtl/evtWordStreamer.sv
`timescale 1ns/1ps
module evtWordStreamer
  import evtw_pkg::*;
#(
  parameter int BC_W = 12,
  parameter int TRIG_W = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bcTick,
  input  logic              trigAccept,
  input  logic              evtValid,
  input  logic              evtFlag,
  input  logic              evtThr,
  input  logic [5:0]        evtAddr,
  input  logic [9:0]        evtAmpl,
  input  logic [9:0]        evtTime,
  output logic [LANE_W-1:0] serData,
  output logic              serSync,
  output logic              overflow
);
  localparam int WORD_W = 2 + ADDR_W + AMPL_W + TIME_W + BC_W + TRIG_W;
  localparam int BEATS  = WORD_W / LANE_W;
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

  ctrl_t             strb;
  logic [CNT_W-1:0]  fillLevel;
  logic [BC_W-1:0]   bcGray;
  logic [TRIG_W-1:0] trigGray;

  evtw_control #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .BEATS(BEATS),
    .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .evtValid(evtValid),
    .strb(strb),
    .serSync(serSync),
    .overflow(overflow),
    .fillLevel(fillLevel)
  );

  evtw_datapath #(
    .BC_W(BC_W),
    .TRIG_W(TRIG_W),
    .FIFO_DEPTH(FIFO_DEPTH),
    .LANE_W(LANE_W),
    .WORD_W(WORD_W)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .bcTick(bcTick),
    .trigAccept(trigAccept),
    .evtFlag(evtFlag),
    .evtThr(evtThr),
    .evtAddr(evtAddr),
    .evtAmpl(evtAmpl),
    .evtTime(evtTime),
    .serData(serData),
    .bcGray(bcGray),
    .trigGray(trigGray)
  );
endmodule

// File: rtl/evtw_checker.sv
`timescale 1ns/1ps
module evtw_checker #(
  parameter int BC_W = 12,
  parameter int TRIG_W = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int BEATS = 24,
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              bcTick,
  input logic              trigAccept,
  input logic              evtValid,
  input logic              serSync,
  input logic              overflow,
  input logic [BC_W-1:0]   bcGray,
  input logic [TRIG_W-1:0] trigGray,
  input logic [CNT_W-1:0]  fillLevel
);
  localparam int GAP_W = $clog2(BEATS + 1);

  logic [GAP_W-1:0] gapCnt;
  logic             seenSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt   <= '0;
      seenSync <= 1'b0;
    end else if (serSync) begin
      gapCnt   <= '0;
      seenSync <= 1'b1;
    end else if (gapCnt != GAP_W'(BEATS)) begin
      gapCnt <= gapCnt + GAP_W'(1);
    end
  end

  AST_BC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    bcTick |=> ($countones(bcGray ^ $past(bcGray)) == 1)); // R2
  AST_BC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !bcTick |=> $stable(bcGray)); // R2
  AST_TRIG_STEP: assert property (@(posedge clk) disable iff (!rstN)
    trigAccept |=> ($countones(trigGray ^ $past(trigGray)) == 1)); // R3
  AST_SYNC_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (serSync && seenSync) |-> (gapCnt >= GAP_W'(BEATS - 1))); // R6
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= CNT_W'(FIFO_DEPTH)); // R9
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && fillLevel == CNT_W'(FIFO_DEPTH)) |=> overflow); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R10
endmodule

bind evtWordStreamer evtw_checker #(
  .BC_W(BC_W),
  .TRIG_W(TRIG_W),
  .FIFO_DEPTH(FIFO_DEPTH),
  .BEATS(BEATS),
  .CNT_W(CNT_W)
) uChk (
  .clk(clk),
  .rstN(rstN),
  .bcTick(bcTick),
  .trigAccept(trigAccept),
  .evtValid(evtValid),
  .serSync(serSync),
  .overflow(overflow),
  .bcGray(bcGray),
  .trigGray(trigGray),
  .fillLevel(fillLevel)
);

// File: tb/sim_evtWordStreamer.sv
`timescale 1ns/1ps
module sim_evtWordStreamer;
  typedef struct packed {
    logic [11:0] nBc;
    logic [7:0]  nTrig;
    logic        flag;
    logic        thr;
    logic [5:0]  addr;
    logic [9:0]  ampl;
    logic [9:0]  tim;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{12'd0,    8'd0,  1'b1, 1'b0, 6'h3F, 10'h000, 10'h3FF},
    '{12'd1,    8'd1,  1'b0, 1'b1, 6'h00, 10'h3FF, 10'h000},
    '{12'd5,    8'd3,  1'b1, 1'b1, 6'h2A, 10'h155, 10'h2AA},
    '{12'd100,  8'd17, 1'b0, 1'b0, 6'h15, 10'h2AA, 10'h155},
    '{12'd1000, 8'd50, 1'b1, 1'b0, 6'h01, 10'h200, 10'h001},
    '{12'd7,    8'd0,  1'b0, 1'b1, 6'h20, 10'h001, 10'h200}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bcTick = 1'b0;
  logic       trigAccept = 1'b0;
  logic       evtValid = 1'b0;
  logic       evtFlag = 1'b0;
  logic       evtThr = 1'b0;
  logic [5:0] evtAddr = '0;
  logic [9:0] evtAmpl = '0;
  logic [9:0] evtTime = '0;
  logic [1:0] serData;
  logic       serSync;
  logic       overflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [11:0] bcModel = '0;
  logic [7:0]  trigModel = '0;

  always #2 clk = ~clk;

  evtWordStreamer u0 (
    .clk(clk), .rstN(rstN), .bcTick(bcTick), .trigAccept(trigAccept),
    .evtValid(evtValid), .evtFlag(evtFlag), .evtThr(evtThr),
    .evtAddr(evtAddr), .evtAmpl(evtAmpl), .evtTime(evtTime),
    .serData(serData), .serSync(serSync), .overflow(overflow)
  );

  function automatic logic [11:0] gray12(input logic [11:0] b);
    return b ^ (b >> 1);
  endfunction
  function automatic logic [7:0] gray8(input logic [7:0] b);
    return b ^ (b >> 1);
  endfunction
  function automatic logic [47:0] mkWord(input vec_t v, input logic [11:0] bc, input logic [7:0] tr);
    return {v.flag, v.thr, v.addr, v.ampl, v.tim, gray12(bc), gray8(tr)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic bcTicks(input int n);
    for (int i = 0; i < n; i++) begin
      bcTick = 1'b1;
      @(negedge clk);
      bcModel++;
    end
    bcTick = 1'b0;
  endtask

  task automatic trigPulses(input int n);
    for (int i = 0; i < n; i++) begin
      trigAccept = 1'b1;
      @(negedge clk);
      trigModel++;
    end
    trigAccept = 1'b0;
  endtask

  task automatic pushEvent(input vec_t v, input bit withTicks, output logic [47:0] expw);
    expw = mkWord(v, bcModel, trigModel);
    evtFlag = v.flag; evtThr = v.thr; evtAddr = v.addr;
    evtAmpl = v.ampl; evtTime = v.tim;
    evtValid = 1'b1;
    bcTick = withTicks;
    trigAccept = withTicks;
    @(negedge clk);
    evtValid = 1'b0; bcTick = 1'b0; trigAccept = 1'b0;
    if (withTicks) begin
      bcModel++;
      trigModel++;
    end
  endtask

  // collects one word starting at the next sync; ends on the negedge after beat 23
  task automatic getWord(output logic [47:0] w, output int waited, output bit syncBad);
    waited = 0;
    syncBad = 1'b0;
    w = '0;
    while (!serSync && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    for (int b = 0; b < 24; b++) begin
      if (b > 0 && serSync) syncBad = 1'b1;
      w = {w[45:0], serData};
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [47:0] expw;
    logic [47:0] got;
    int waited;
    bit syncBad;
    vec_t v;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(serData == 2'b00 && serSync == 1'b0 && overflow == 1'b0, "R1 reset outputs",
        {45'd0, serData, serSync}, 48'd0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      bcTicks(int'(VEC[i].nBc));
      trigPulses(int'(VEC[i].nTrig));
      pushEvent(VEC[i], 1'b0, expw);
      getWord(got, waited, syncBad);
      chk(got == expw, "R5 R2 R3 word content", got, expw);
      chk(waited == 1, "R7 idle latency", 48'(waited), 48'd1);
      chk(!syncBad, "R6 sync on beat 0 only", {47'd0, syncBad}, 48'd0);
      chk(serData == 2'b00 && !serSync, "R8 idle lane", {46'd0, serData}, 48'd0);
    end
    // first vector ran with counters straight from reset (R1)

    // R4: same-cycle increment is not captured
    v = VEC[2];
    pushEvent(v, 1'b1, expw);
    getWord(got, waited, syncBad);
    chk(got == expw, "R4 capture before increment", got, expw);
    v = VEC[3];
    pushEvent(v, 1'b0, expw);
    getWord(got, waited, syncBad);
    chk(got == expw, "R4 increment visible next event", got, expw);

    // R2: bunch counter wrap
    bcTicks(int'(12'd4095 - bcModel));
    pushEvent(VEC[0], 1'b0, expw);
    getWord(got, waited, syncBad);
    chk(got[19:8] == 12'h800, "R2 bunch Gray at full scale", {36'd0, got[19:8]}, 48'h800);
    bcTicks(1);
    pushEvent(VEC[0], 1'b0, expw);
    getWord(got, waited, syncBad);
    chk(got[19:8] == 12'h000, "R2 bunch wrap to zero", {36'd0, got[19:8]}, 48'h0);

    // R3: trigger counter wrap
    trigPulses(int'(8'd255 - trigModel));
    pushEvent(VEC[1], 1'b0, expw);
    getWord(got, waited, syncBad);
    chk(got[7:0] == 8'h80, "R3 trigger Gray at full scale", {40'd0, got[7:0]}, 48'h80);
    trigPulses(1);
    pushEvent(VEC[1], 1'b0, expw);
    getWord(got, waited, syncBad);
    chk(got[7:0] == 8'h00, "R3 trigger wrap to zero", {40'd0, got[7:0]}, 48'h0);

    // R10: flag clear before any loss
    chk(overflow == 1'b0, "R10 no loss yet", {47'd0, overflow}, 48'd0);

    // R9 R10 R7: burst of 20 events, 17 fit
    begin
      logic [47:0] gotW [17];
      int waits [17];
      bit bads [17];
      vec_t bv;
      fork
        begin
          for (int i = 0; i < 20; i++) begin
            evtFlag = 1'b1; evtThr = 1'b0; evtAddr = 6'(i);
            evtAmpl = 10'h123; evtTime = 10'h0F0;
            evtValid = 1'b1;
            @(negedge clk);
          end
          evtValid = 1'b0;
        end
        begin
          for (int k = 0; k < 17; k++) getWord(gotW[k], waits[k], bads[k]);
        end
      join
      chk(overflow == 1'b1, "R10 overflow after drop", {47'd0, overflow}, 48'd1);
      for (int k = 0; k < 17; k++) begin
        bv = '{12'd0, 8'd0, 1'b1, 1'b0, 6'(k), 10'h123, 10'h0F0};
        expw = mkWord(bv, bcModel, trigModel);
        chk(gotW[k] == expw, "R9 order preserved", gotW[k], expw);
        if (k > 0) chk(waits[k] == 0, "R7 gapless words", 48'(waits[k]), 48'd0);
      end
      syncBad = 1'b0;
      for (int c = 0; c < 60; c++) begin
        if (serSync || serData != 2'b00) syncBad = 1'b1;
        @(negedge clk);
      end
      chk(!syncBad, "R9 dropped events never sent", {47'd0, syncBad}, 48'd0);
      chk(overflow == 1'b1, "R10 overflow sticky", {47'd0, overflow}, 48'd1);
    end

    // R1 R10: reset clears the flag
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(overflow == 1'b0 && serSync == 1'b0 && serData == 2'b00, "R10 R1 reset clears",
        {46'd0, overflow, serSync}, 48'd0);
    rstN = 1'b1;
    bcModel = '0;
    trigModel = '0;
    @(negedge clk);
    pushEvent(VEC[4], 1'b0, expw);
    getWord(got, waited, syncBad);
    chk(got == expw, "R1 counters zero after reset", got, expw);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule